// File: doc/BRIEF.md
# Mode-Banked Register File Switcher

This block keeps the sixteen 32-bit general registers that an instruction datapath sees, together with shadow copies that belong to the processor's privilege modes. When the mode changes, it parks the outgoing mode's private registers in that mode's shadow slots. It then brings the incoming mode's copies into the live view. The private registers are the stack pointer (r13), the link register (r14) and the saved status word. A separate set of high registers, r8 to r12, is exchanged only when the fast-interrupt mode is entered or left.

The datapath reads the live view through a combinational read port and writes it through a single write port. The saved status word has its own read and write pair. A mode change is requested with a strobe and the 5-bit target encoding. The whole swap takes effect on one clock edge. A write issued in the same cycle as the change lands in the new mode's view. The ports are plain register-file ports, with no valid/ready handshake: every access completes in one cycle, so there is never back-pressure.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset, all sixteen live registers read zero, the saved status word reads zero, every shadow slot holds zero, and the current mode is System (5'h1F).
- R2: Mode encodings are User 5'h10, Fast-interrupt 5'h11, IRQ 5'h12, Supervisor 5'h13, Abort 5'h17, Undefined 5'h1B and System 5'h1F. User, System and every other encoding share one bank. Each of the other five modes has its own bank.
- R3: A change request whose target equals the current mode leaves registers, status word and mode unchanged.
- R4: On a change between different banks, r13 and r14 are stored into the old bank and reloaded from the new bank at that clock edge, and the current-mode output takes the new encoding at the same edge.
- R5: r8 to r12 are stored and reloaded only when the old or the new mode is Fast-interrupt. One set belongs to Fast-interrupt and one set is shared by all other modes.
- R6: The saved status word is banked per bank: on a bank change the old value is stored and the new bank's value appears on the status read port.
- R7: A register or status write issued in the same cycle as a mode change updates the new mode's view, while the old bank stores the pre-write value.
- R8: Reads are combinational from the live view. A change between User and System updates only the reported mode.
- R9: r0 to r7 and r15 are never exchanged by a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Target mode encoding |
| mode_chg_i | input | 1 | Mode change strobe |
| cur_mode_o | output | 5 | Current mode encoding |
| rd_addr_i | input | 4 | Live register read index |
| rd_data_o | output | 32 | Live register read data |
| wr_en_i | input | 1 | Live register write enable |
| wr_addr_i | input | 4 | Live register write index |
| wr_data_i | input | 32 | Live register write data |
| ssr_rd_o | output | 32 | Current saved status word |
| ssr_wr_en_i | input | 1 | Saved status write enable |
| ssr_wr_data_i | input | 32 | Saved status write data |

## Verification
The bench first marks every register with a distinct value. It then walks through chains of modes: into IRQ, on to Fast-interrupt, out to Supervisor and back to System. This shows whether r13, r14 and the status word follow the bank, and whether r8 to r12 follow only the Fast-interrupt set. Same-mode requests, User/System hops and unknown encodings show that no exchange occurs where none is due. Writes issued together with a change show which view the write reaches. A long random run of mixed changes and writes, compared every cycle against a behavioural model, catches wrong slot pairing across arbitrary round trips.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int NREG    = 16;
  localparam int AW      = $clog2(NREG);
  localparam int SP_IDX  = 13;
  localparam int LR_IDX  = 14;
  localparam int HI_BASE = 8;
  localparam int HI_CNT  = 5;
  localparam int NBANK   = 6;
  localparam int BW      = $clog2(NBANK);

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  typedef enum logic [BW-1:0] {
    BANK_SHARED = 3'd0,
    BANK_FAST   = 3'd1,
    BANK_IRQ    = 3'd2,
    BANK_SVC    = 3'd3,
    BANK_ABT    = 3'd4,
    BANK_UND    = 3'd5
  } bank_e;
endpackage

// File: rtl/mbr_bank_decode.sv
module mbr_bank_decode
  import mbr_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank
);
  always_comb begin
    unique case (mode)
      MODE_FIQ: bank = BANK_FAST;
      MODE_IRQ: bank = BANK_IRQ;
      MODE_SVC: bank = BANK_SVC;
      MODE_ABT: bank = BANK_ABT;
      MODE_UND: bank = BANK_UND;
      default:  bank = BANK_SHARED;
    endcase
  end
endmodule

// File: rtl/mbr_shadow_store.sv
module mbr_shadow_store
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swap,
  input  logic                        hi_swap,
  input  bank_e                       old_bank,
  input  bank_e                       new_bank,
  input  logic [DW-1:0]               live_sp,
  input  logic [DW-1:0]               live_lr,
  input  logic [DW-1:0]               live_ssr,
  input  logic [HI_CNT-1:0][DW-1:0]   live_hi,
  output logic [DW-1:0]               new_sp,
  output logic [DW-1:0]               new_lr,
  output logic [DW-1:0]               new_ssr,
  output logic [HI_CNT-1:0][DW-1:0]   new_hi
);
  logic [NBANK-1:0][DW-1:0]          sp_q, lr_q, ssr_q;
  logic [1:0][HI_CNT-1:0][DW-1:0]    hi_q;

  logic old_fast, new_fast;
  assign old_fast = (old_bank == BANK_FAST);
  assign new_fast = (new_bank == BANK_FAST);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_q[b]  <= '0;
        lr_q[b]  <= '0;
        ssr_q[b] <= '0;
      end else if (swap && (int'(old_bank) == b)) begin
        sp_q[b]  <= live_sp;
        lr_q[b]  <= live_lr;
        ssr_q[b] <= live_ssr;
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_hiset
    always_ff @(posedge clk) begin
      if (!rst_n)
        hi_q[s] <= '0;
      else if (hi_swap && (old_fast == (s == 1)))
        hi_q[s] <= live_hi;
    end
  end

  assign new_sp  = sp_q[new_bank];
  assign new_lr  = lr_q[new_bank];
  assign new_ssr = ssr_q[new_bank];
  assign new_hi  = hi_q[new_fast];
endmodule

// File: rtl/mbr_live_array.sv
module mbr_live_array
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swap,
  input  logic                        hi_swap,
  input  logic [DW-1:0]               load_sp,
  input  logic [DW-1:0]               load_lr,
  input  logic [DW-1:0]               load_ssr,
  input  logic [HI_CNT-1:0][DW-1:0]   load_hi,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic                        ssr_wr_en,
  input  logic [DW-1:0]               ssr_wr_data,
  input  logic [AW-1:0]               rd_addr,
  output logic [DW-1:0]               rd_data,
  output logic [DW-1:0]               live_sp,
  output logic [DW-1:0]               live_lr,
  output logic [DW-1:0]               live_ssr,
  output logic [HI_CNT-1:0][DW-1:0]   live_hi
);
  logic [NREG-1:0][DW-1:0] rf_q;
  logic [DW-1:0]           ssr_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_HI = (i >= HI_BASE) && (i < HI_BASE + HI_CNT);
    localparam bit IS_SP = (i == SP_IDX);
    localparam bit IS_LR = (i == LR_IDX);
    localparam int HK    = IS_HI ? i - HI_BASE : 0;
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i));

    if (IS_HI) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n)       rf_q[i] <= '0;
        else if (hit)     rf_q[i] <= wr_data;
        else if (hi_swap) rf_q[i] <= load_hi[HK];
      end
    end else if (IS_SP) begin : g_sp
      always_ff @(posedge clk) begin
        if (!rst_n)    rf_q[i] <= '0;
        else if (hit)  rf_q[i] <= wr_data;
        else if (swap) rf_q[i] <= load_sp;
      end
    end else if (IS_LR) begin : g_lr
      always_ff @(posedge clk) begin
        if (!rst_n)    rf_q[i] <= '0;
        else if (hit)  rf_q[i] <= wr_data;
        else if (swap) rf_q[i] <= load_lr;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   rf_q[i] <= '0;
        else if (hit) rf_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ssr_q <= '0;
    else if (ssr_wr_en) ssr_q <= ssr_wr_data;
    else if (swap)      ssr_q <= load_ssr;
  end

  for (genvar k = 0; k < HI_CNT; k++) begin : g_hiout
    assign live_hi[k] = rf_q[HI_BASE + k];
  end

  assign rd_data  = rf_q[rd_addr];
  assign live_sp  = rf_q[SP_IDX];
  assign live_lr  = rf_q[LR_IDX];
  assign live_ssr = ssr_q;
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode_i,
  input  logic          mode_chg_i,
  output logic [4:0]    cur_mode_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] ssr_rd_o,
  input  logic          ssr_wr_en_i,
  input  logic [DW-1:0] ssr_wr_data_i
);
  logic [4:0] mode_q;
  bank_e      old_bank, new_bank;
  logic       mode_move, swap_w, hi_swap_w;

  logic [DW-1:0]             live_sp, live_lr, live_ssr;
  logic [HI_CNT-1:0][DW-1:0] live_hi;
  logic [DW-1:0]             new_sp, new_lr, new_ssr;
  logic [HI_CNT-1:0][DW-1:0] new_hi;

  mbr_bank_decode u_dec_old (.mode(mode_q), .bank(old_bank));
  mbr_bank_decode u_dec_new (.mode(mode_i), .bank(new_bank));

  assign mode_move = mode_chg_i && (mode_i != mode_q);
  assign swap_w    = mode_move && (old_bank != new_bank);
  assign hi_swap_w = swap_w && ((old_bank == BANK_FAST) || (new_bank == BANK_FAST));

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= MODE_SYS;
    else if (mode_move) mode_q <= mode_i;
  end

  mbr_shadow_store #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .swap(swap_w), .hi_swap(hi_swap_w),
    .old_bank(old_bank), .new_bank(new_bank),
    .live_sp(live_sp), .live_lr(live_lr), .live_ssr(live_ssr), .live_hi(live_hi),
    .new_sp(new_sp), .new_lr(new_lr), .new_ssr(new_ssr), .new_hi(new_hi)
  );

  mbr_live_array #(.DW(DW)) u_live (
    .clk(clk), .rst_n(rst_n),
    .swap(swap_w), .hi_swap(hi_swap_w),
    .load_sp(new_sp), .load_lr(new_lr), .load_ssr(new_ssr), .load_hi(new_hi),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .ssr_wr_en(ssr_wr_en_i), .ssr_wr_data(ssr_wr_data_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o),
    .live_sp(live_sp), .live_lr(live_lr), .live_ssr(live_ssr), .live_hi(live_hi)
  );

  assign cur_mode_o = mode_q;
  assign ssr_rd_o   = live_ssr;
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    mode_i,
  input logic          mode_chg_i,
  input logic [4:0]    cur_mode_o,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          ssr_wr_en_i,
  input logic [DW-1:0] ssr_rd_o,
  input logic          swap,
  input logic          hi_swap,
  input logic [DW-1:0] new_sp,
  input logic [DW-1:0] live_sp,
  input logic [DW-1:0] live_r8
);
  logic wr_sp, wr_r8;
  assign wr_sp = wr_en_i && (wr_addr_i == AW'(SP_IDX));
  assign wr_r8 = wr_en_i && (wr_addr_i == AW'(HI_BASE));

  assert_same_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg_i && (mode_i == cur_mode_o)) |=> $stable(cur_mode_o));

  assert_mode_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_i |=> (cur_mode_o == $past(mode_i)));

  assert_sp_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !wr_sp) |=> (live_sp == $past(new_sp)));

  assert_sp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap && !wr_sp) |=> $stable(live_sp));

  assert_ssr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap && !ssr_wr_en_i) |=> $stable(ssr_rd_o));

  assert_hi_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_swap && !wr_r8) |=> $stable(live_r8));
endmodule

bind mode_bank_regfile mbr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_chg_i(mode_chg_i),
  .cur_mode_o(cur_mode_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .ssr_wr_en_i(ssr_wr_en_i), .ssr_rd_o(ssr_rd_o),
  .swap(swap_w), .hi_swap(hi_swap_w), .new_sp(new_sp), .live_sp(live_sp),
  .live_r8(live_hi[0])
);

// File: tb/tb_mode_bank_regfile.sv
module tb_mode_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i;
  logic        mode_chg_i;
  logic [4:0]  cur_mode_o;
  logic [3:0]  rd_addr_i, wr_addr_i;
  logic [31:0] rd_data_o, wr_data_i, ssr_rd_o, ssr_wr_data_i;
  logic        wr_en_i, ssr_wr_en_i;

  always #5 clk = ~clk;

  mode_bank_regfile dut (.*);

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [31:0] m_live [16];
  logic [31:0] m_sp [6], m_lr [6], m_ssr [6];
  logic [31:0] m_hi [2][5];
  logic [31:0] m_cur_ssr;
  logic [4:0]  m_mode;

  logic [4:0] mode_list [9] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00, 5'h15};

  function automatic int bank_of(logic [4:0] m);
    if (m == 5'h11) return 1;
    if (m == 5'h12) return 2;
    if (m == 5'h13) return 3;
    if (m == 5'h17) return 4;
    if (m == 5'h1B) return 5;
    return 0;
  endfunction

  task automatic model_reset();
    foreach (m_live[i]) m_live[i] = '0;
    for (int b = 0; b < 6; b++) begin m_sp[b] = '0; m_lr[b] = '0; m_ssr[b] = '0; end
    for (int s = 0; s < 2; s++) for (int k = 0; k < 5; k++) m_hi[s][k] = '0;
    m_cur_ssr = '0;
    m_mode = 5'h1F;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, tag, act, exp);
    end
  endtask

  task automatic step(bit chg, logic [4:0] md, bit we, logic [3:0] wa, logic [31:0] wd,
                      bit swe, logic [31:0] sd, logic [3:0] ra);
    int ob, nb;
    @(negedge clk);
    mode_chg_i = chg; mode_i = md; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    ssr_wr_en_i = swe; ssr_wr_data_i = sd; rd_addr_i = ra;
    #1;
    chk($sformatf("r%0d", ra), rd_data_o, m_live[ra]);
    chk("status", ssr_rd_o, m_cur_ssr);
    chk("mode", {27'b0, cur_mode_o}, {27'b0, m_mode});
    @(posedge clk);
    if (chg && md != m_mode) begin
      ob = bank_of(m_mode);
      nb = bank_of(md);
      if (ob != nb) begin
        if (ob == 1 || nb == 1)
          for (int k = 0; k < 5; k++) begin
            m_hi[ob == 1][k] = m_live[8 + k];
            m_live[8 + k]    = m_hi[nb == 1][k];
          end
        m_sp[ob] = m_live[13]; m_lr[ob] = m_live[14]; m_ssr[ob] = m_cur_ssr;
        m_live[13] = m_sp[nb]; m_live[14] = m_lr[nb]; m_cur_ssr = m_ssr[nb];
      end
      m_mode = md;
    end
    if (we)  m_live[wa] = wd;
    if (swe) m_cur_ssr = sd;
  endtask

  task automatic idle(logic [3:0] ra);  step(0, 5'h0, 0, 0, 0, 0, 0, ra); endtask
  task automatic go(logic [4:0] md);    step(1, md, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); step(0, 5'h0, 1, a, d, 0, 0, a); endtask
  task automatic swr(logic [31:0] d);   step(0, 5'h0, 0, 0, 0, 1, d, 0); endtask
  task automatic dump();
    for (int i = 0; i < 16; i++) idle(4'(i));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_chg_i = 0; mode_i = 0; wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    ssr_wr_en_i = 0; ssr_wr_data_i = 0; rd_addr_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cur_req = "R1"; dump();

    cur_req = "R9";
    for (int i = 0; i < 16; i++) wr(4'(i), 32'h1000_0000 + i);
    swr(32'h5A5A_0000);
    cur_req = "R4"; go(5'h12);
    wr(13, 32'h2000_000D); wr(14, 32'h2000_000E);
    cur_req = "R6"; swr(32'h2222_2222);
    cur_req = "R5"; go(5'h11);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'hF000_0000 + i);
    swr(32'hF1F1_F1F1);
    go(5'h13); dump();
    cur_req = "R9"; go(5'h1F); dump();
    cur_req = "R5"; go(5'h11); dump();
    cur_req = "R4"; go(5'h12); dump();

    cur_req = "R3";
    step(1, 5'h12, 0, 0, 0, 0, 0, 13);
    dump();

    cur_req = "R7";
    step(1, 5'h13, 1, 13, 32'hDEAD_0013, 1, 32'h0BAD_0013, 13);
    dump();
    go(5'h12); go(5'h13); dump();

    cur_req = "R8";
    go(5'h10); wr(13, 32'h0000_1013);
    go(5'h1F); dump();

    cur_req = "R2";
    go(5'h15); dump();
    go(5'h00); go(5'h1B); dump();
    go(5'h17); dump();

    cur_req = "R4";
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 3);
      step(sel == 0, mode_list[$urandom_range(0, 8)],
           sel != 3, 4'($urandom_range(0, 15)), $urandom(),
           $urandom_range(0, 3) == 0, $urandom(), 4'($urandom_range(0, 15)));
    end
    dump();

    done = 1;
    summary();
    $finish;
  end
endmodule